// File: doc/BRIEF.md
# Byte-Addressed Data Memory with Store-Width Control

This block is a small synchronous data store for a processor datapath. It takes a 32-bit byte address, a 32-bit write value, an enable and a 2-bit access mode. The mode selects one of four operations: a full-word read, a single-byte store, a two-byte store or a full-word store. Only the address bits that pick a word inside the physical depth are decoded, so higher addresses alias onto the same storage.

Inside a word, bytes are laid out big-endian: the byte at the lowest address sits in the most significant lane. Narrow stores place the low bits of the write value into the addressed lanes and leave the other lanes as they were. Halfword and word accesses must be naturally aligned. A misaligned access raises an error flag in the same cycle and changes nothing.

Stores take effect on the rising clock edge. Read data is combinational from the addressed word, and the error flag is combinational too.

Top module: `byte_mem`

## Requirements
- R1: While reset is low, every word is cleared, so a word read after reset returns 0x00000000.
- R2: When `en` is low, nothing is stored, `rdata` is 0 and `misalign` is 0, whatever the other inputs are.
- R3: With `en` high and `mode` = 2'b00 at an address whose two low bits are 00, `rdata` shows the addressed word in the same cycle, and no store happens.
- R4: With `en` high and `mode` = 2'b01, the byte at byte offset k = `addr[1:0]` (any k) takes `wdata[7:0]` at the next rising edge. The lane for offset k is bits [31-8k -: 8]. The other three bytes of the word keep their values.
- R5: With `en` high and `mode` = 2'b10 and `addr[0]` = 0, `wdata[15:0]` is stored at the next rising edge. Offset 0 goes to bits 31:16 and offset 2 goes to bits 15:0. The other half of the word is unchanged.
- R6: With `en` high and `mode` = 2'b11 and `addr[1:0]` = 00, the whole `wdata` replaces the addressed word at the next rising edge.
- R7: A halfword access with `addr[0]` = 1, or a word read or word store with `addr[1:0]` not 00, drives `misalign` high in that cycle. In that case the memory is left unchanged and `rdata` is 0.
- R8: Only `addr[IDX_W+1:2]` selects the word, where IDX_W = log2(DEPTH). Addresses that differ only above that field reach the same word.
- R9: A byte store never raises `misalign`, at any of the four offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores commit on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears the storage |
| en | input | 1 | Access enable |
| mode | input | 2 | 00 word read, 01 byte store, 10 halfword store, 11 word store |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Store value; narrow stores use its low bits |
| rdata | output | 32 | Addressed word on an aligned enabled read, otherwise 0 |
| misalign | output | 1 | Alignment error for the current access |

## Verification
`rdata` and `misalign` are combinational, so they are due in the same cycle as the stimulus. The bench applies each access just after a falling edge and compares both outputs one time step later, before the next rising edge. A store becomes visible only after the rising edge that follows it. The reference model applies each store to its own byte array at that edge, so every later read is compared against memory contents that include the store. A byte-wise model fed with mixed widths, offsets, alignments and aliased addresses is compared on every cycle.

// File: rtl/byte_mem_pkg.sv
package byte_mem_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        ACC_RD_WORD  = 2'b00,
        ACC_ST_BYTE  = 2'b01,
        ACC_ST_HALF  = 2'b10,
        ACC_ST_WORD  = 2'b11
    } acc_mode_e;
endpackage

// File: rtl/byte_mem_align.sv
module byte_mem_align
    import byte_mem_pkg::*;
(
    input  logic             en,
    input  acc_mode_e        mode,
    input  logic [OFF_W-1:0] off,
    output logic             err,
    output logic             st_go,
    output logic             rd_go
);
    logic bad_d;

    always_comb begin
        unique case (mode)
            ACC_ST_BYTE: bad_d = 1'b0;
            ACC_ST_HALF: bad_d = off[0];
            default:     bad_d = (off != '0);
        endcase
        err   = en && bad_d;
        st_go = en && !bad_d && (mode != ACC_RD_WORD);
        rd_go = en && !bad_d && (mode == ACC_RD_WORD);
    end
endmodule

// File: rtl/byte_mem_steer.sv
module byte_mem_steer
    import byte_mem_pkg::*;
(
    input  acc_mode_e         mode,
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] din,
    output logic [LANES-1:0]  lane_en,
    output logic [WORD_W-1:0] lane_data
);
    // Lane k holds byte offset k, placed at bits [8*(LANES-1-k) +: 8].
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HI = 8 * (LANES - 1 - k);
        always_comb begin
            unique case (mode)
                ACC_ST_BYTE: begin
                    lane_en[k]           = (off == OFF_W'(k));
                    lane_data[HI +: 8]   = din[7:0];
                end
                ACC_ST_HALF: begin
                    lane_en[k]           = (off[OFF_W-1:1] == (OFF_W-1)'(k >> 1));
                    lane_data[HI +: 8]   = (k % 2 == 0) ? din[15:8] : din[7:0];
                end
                ACC_ST_WORD: begin
                    lane_en[k]           = 1'b1;
                    lane_data[HI +: 8]   = din[HI +: 8];
                end
                default: begin
                    lane_en[k]           = 1'b0;
                    lane_data[HI +: 8]   = 8'h00;
                end
            endcase
        end
    end
endmodule

// File: rtl/byte_mem.sv
module byte_mem
    import byte_mem_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [1:0]  mode,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        misalign
);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
    } st_t;

    st_t st_d, st_q;

    acc_mode_e         mode_e;
    logic [OFF_W-1:0]  off;
    logic [IDX_W-1:0]  idx;
    logic              st_go, rd_go;
    logic [LANES-1:0]  lane_en;
    logic [WORD_W-1:0] lane_data;
    logic              unused_hi;

    assign mode_e    = acc_mode_e'(mode);
    assign off       = addr[OFF_W-1:0];
    assign idx       = addr[IDX_W+OFF_W-1:OFF_W];
    assign unused_hi = ^addr[31:IDX_W+OFF_W];

    byte_mem_align u_align (
        .en    (en),
        .mode  (mode_e),
        .off   (off),
        .err   (misalign),
        .st_go (st_go),
        .rd_go (rd_go)
    );

    byte_mem_steer u_steer (
        .mode      (mode_e),
        .off       (off),
        .din       (wdata),
        .lane_en   (lane_en),
        .lane_data (lane_data)
    );

    always_comb begin
        st_d = st_q;
        if (st_go) begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_en[k]) begin
                    st_d.mem[idx][8*(LANES-1-k) +: 8] = lane_data[8*(LANES-1-k) +: 8];
                end
            end
        end
        rdata = rd_go ? st_q.mem[idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a disabled cycle is silent on both outputs
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (rdata == '0) && !misalign);
    // R2: a disabled cycle leaves storage alone
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.mem));
    // R3: reads never modify storage
    a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        en && mode_e == ACC_RD_WORD |=> $stable(st_q.mem));
    // R4: a byte store touches exactly one lane
    a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        en && mode_e == ACC_ST_BYTE |-> $countones(lane_en) == 1);
    // R5: an aligned halfword store touches exactly two lanes
    a_r5_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        en && mode_e == ACC_ST_HALF && !misalign |-> $countones(lane_en) == 2);
    // R6: an aligned word store lands whole
    a_r6_word_lands: assert property (@(posedge clk) disable iff (!rst_n)
        en && mode_e == ACC_ST_WORD && !misalign |=> st_q.mem[$past(idx)] == $past(wdata));
    // R7: a misaligned access changes nothing
    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> $stable(st_q.mem));
    // R7: misaligned reads return zero
    a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> rdata == '0);
    // R9: byte stores are never misaligned
    a_r9_byte_ok: assert property (@(posedge clk) disable iff (!rst_n)
        en && mode_e == ACC_ST_BYTE |-> !misalign);
endmodule

// File: tb/byte_mem_test.sv
module byte_mem_test;
    localparam int DEPTH = 64;
    localparam int IDX_W = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [1:0]  mode;
    logic [31:0] addr, wdata;
    logic [31:0] rdata;
    logic        misalign;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] model [DEPTH*4];

    always #2 clk = ~clk;

    byte_mem #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
        .addr(addr), .wdata(wdata), .rdata(rdata), .misalign(misalign)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (mode %b addr %h)", req, act, exp, mode, addr);
        end
    endtask

    // one access: drive after the falling edge, compare outputs, then model the edge
    task automatic op(input string req, input logic e, input logic [1:0] m,
                      input logic [31:0] a, input logic [31:0] d);
        int base, o;
        logic bad;
        logic [31:0] exp_r;
        @(negedge clk);
        en = e; mode = m; addr = a; wdata = d;
        #1;
        o    = int'(a[1:0]);
        base = int'(a[IDX_W+1:2]) * 4;
        bad  = (m == 2'b10) ? a[0] : (m == 2'b01) ? 1'b0 : (o != 0);
        exp_r = (e && m == 2'b00 && !bad) ?
                {model[base], model[base+1], model[base+2], model[base+3]} : 32'h0;
        check({req, " rdata"}, rdata, exp_r);
        check({req, " misalign"}, {31'h0, misalign}, {31'h0, e && bad});
        @(posedge clk);
        if (e && !bad) begin
            case (m)
                2'b01: model[base+o] = d[7:0];
                2'b10: begin model[base+o] = d[15:8]; model[base+o+1] = d[7:0]; end
                2'b11: begin
                    model[base]   = d[31:24]; model[base+1] = d[23:16];
                    model[base+2] = d[15:8];  model[base+3] = d[7:0];
                end
                default: ;
            endcase
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH*4; i++) model[i] = 8'h00;
        rst_n = 1'b0; en = 1'b0; mode = 2'b00; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: cleared storage
        op("R1", 1, 2'b00, 32'h0000_0000, 0);
        op("R1", 1, 2'b00, 32'h0000_00FC, 0);
        // R6: word stores, R3: read back
        op("R6", 1, 2'b11, 32'h0000_0010, 32'hDEAD_BEEF);
        op("R3", 1, 2'b00, 32'h0000_0010, 0);
        op("R6", 1, 2'b11, 32'h0000_0020, 32'h0123_4567);
        op("R3", 1, 2'b00, 32'h0000_0020, 32'hFFFF_FFFF);
        // R4, R9: byte stores at every offset
        for (int k = 0; k < 4; k++) begin
            op("R4", 1, 2'b01, 32'h0000_0010 + k, 32'hAABB_CC00 + k + 8'h50);
            op("R9", 1, 2'b00, 32'h0000_0010, 0);
        end
        // R5: halfword stores at both offsets
        op("R5", 1, 2'b10, 32'h0000_0020, 32'h7777_BEEF);
        op("R5", 1, 2'b00, 32'h0000_0020, 0);
        op("R5", 1, 2'b10, 32'h0000_0022, 32'h1111_CAFE);
        op("R5", 1, 2'b00, 32'h0000_0020, 0);
        // R7: misaligned accesses
        op("R7", 1, 2'b10, 32'h0000_0021, 32'h5555_5555);
        op("R7", 1, 2'b11, 32'h0000_0022, 32'h6666_6666);
        op("R7", 1, 2'b11, 32'h0000_0013, 32'h6666_6666);
        op("R7", 1, 2'b00, 32'h0000_0011, 0);
        op("R7", 1, 2'b00, 32'h0000_0020, 0);
        // R2: disabled accesses
        op("R2", 0, 2'b11, 32'h0000_0020, 32'h9999_9999);
        op("R2", 0, 2'b00, 32'h0000_0021, 0);
        op("R2", 1, 2'b00, 32'h0000_0020, 0);
        // R8: aliasing above the index field
        op("R8", 1, 2'b11, 32'hF000_0104, 32'h0BAD_F00D);
        op("R8", 1, 2'b00, 32'h0000_0004, 0);
        op("R8", 1, 2'b01, 32'h8000_0007, 32'h0000_0042);
        op("R8", 1, 2'b00, 32'h1234_5604, 0);
        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            op("R3", ($urandom % 8) != 0, 2'($urandom), {24'($urandom), 8'($urandom)}, $urandom);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule